// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Comparator

This unit compares two equal-width unsigned operands that a runtime split vector divides into independent lanes. The operands are viewed as a row of fixed-width slices (4 bits each by default). Each bit of the split vector sits on the border between two neighbouring slices. A set bit cuts the operands there, and a clear bit joins the two slices into one wider lane. With the default 16-bit operands, the split vector can describe one 16-bit lane, two 8-bit lanes, four 4-bit lanes, or any mixed layout in between.

For every lane the unit works out six relations: equal, not-equal, less-than, less-or-equal, greater-than and greater-or-equal. Each relation has an output vector with one bit per slice. A lane reports its result only in the bit of its lowest slice, and the bits of its other slices read zero. A consumer that runs under the same split vector can therefore find each lane's flag at the lane's base slice.

The unit is purely combinational. Its outputs follow the operands and the split vector with no clock and no storage.

Top module: `simd_lane_compare`

## Requirements
- R1: Split bit j (j = 0 to NSLICE-2) lies between slice j (operand bits [4j+3:4j]) and slice j+1. When the bit is 1 the two slices belong to different lanes. When it is 0 they belong to the same lane. Each flag output has NSLICE bits, which is one more than the width of the split vector.
- R2: At the base slice of every lane, the not-equal bit is the complement of the equal bit. The equal bit is 1 exactly when the lane's operand fields match.
- R3: With the split vector all zero, the whole operand forms one lane. Its six results appear at bit 0, and bits 1 to NSLICE-1 of every flag output are 0.
- R4: A flag bit can be 1 only at a lane base. Lane bases are bit 0, and bit k for every k where split bit k-1 is 1. All other bits of all six outputs are 0.
- R5: At every lane base, exactly one of less-than, equal and greater-than is 1. Less-or-equal equals less-than OR equal, and greater-or-equal equals greater-than OR equal.
- R6: With every split bit set (3'b111 by default), slice k forms its own lane and its result sits at flag bit k.
- R7: With split vector 3'b010, the upper byte's result sits at bit 2 and the lower byte's result sits at bit 0. Bits 1 and 3 are 0.
- R8: Each lane field is compared as an unsigned number, so a field whose top bit is 1 is greater than any field whose top bit is 0.
- R9: A lane's result depends only on the operand bits inside that lane. This holds for every split value, mixed layouts included (for example 3'b001, 3'b100, 3'b011, 3'b101 and 3'b110).
- R10: The outputs are a combinational function of the current inputs and react within the same cycle that an input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| cut_i | input | NSLICE-1 | Split vector; bit j cuts between slice j and slice j+1 |
| eq_o | output | NSLICE | Lane equal flags at lane base bits |
| ne_o | output | NSLICE | Lane not-equal flags at lane base bits |
| lt_o | output | NSLICE | Lane less-than flags at lane base bits |
| le_o | output | NSLICE | Lane less-or-equal flags at lane base bits |
| gt_o | output | NSLICE | Lane greater-than flags at lane base bits |
| ge_o | output | NSLICE | Lane greater-or-equal flags at lane base bits |

## Verification
The bench goes through all eight split values. For each one it applies pseudo-random operand pairs in which whole slices are often copied from one operand to the other, plus a full sweep of operands that repeat a single nibble. This combination exposes three faults: a chain that leaks a greater-than or equal decision across a set split bit, which would corrupt the neighbouring lane, a chain that ignores lower slices when the upper slices tie, and a signed comparison, which would flip results whenever the top bit differs. Every output is compared with a lane-by-lane model built from the split vector. A design that placed a flag at the lane's top slice, or left stray ones at non-base bits, would fail at once in the two-lane and mixed layouts.

// File: rtl/simd_lane_compare_pkg.sv
package simd_lane_compare_pkg;
    localparam int DEF_WIDTH = 16;
    localparam int DEF_SLICE = 4;

    // Partial decision for a slice or a chained group of slices
    typedef struct packed {
        logic eq;
        logic gt;
    } rel_t;
endpackage

// File: rtl/slice_rel.sv
module slice_rel
    import simd_lane_compare_pkg::*;
#(
    parameter int SLICE = DEF_SLICE
) (
    input  logic [SLICE-1:0] a_i,
    input  logic [SLICE-1:0] b_i,
    output rel_t             rel_o
);
    rel_t rel_d;

    always_comb begin
        rel_d.eq = (a_i == b_i);
        rel_d.gt = (a_i > b_i);
    end

    assign rel_o = rel_d;
endmodule

// File: rtl/lane_chain.sv
module lane_chain
    import simd_lane_compare_pkg::*;
#(
    parameter int NSLICE = DEF_WIDTH / DEF_SLICE
) (
    input  rel_t [NSLICE-1:0] slice_i,
    input  logic [NSLICE-2:0] cut_i,
    output rel_t [NSLICE-1:0] acc_o
);
    rel_t [NSLICE-1:0] acc_d;

    // Walk from the top slice down; a set cut restarts the decision
    always_comb begin
        rel_t run;
        run = slice_i[NSLICE-1];
        acc_d[NSLICE-1] = run;
        for (int i = NSLICE - 2; i >= 0; i--) begin
            if (cut_i[i]) begin
                run = slice_i[i];
            end else begin
                run.gt = run.gt | (run.eq & slice_i[i].gt);
                run.eq = run.eq & slice_i[i].eq;
            end
            acc_d[i] = run;
        end
    end

    assign acc_o = acc_d;
endmodule

// File: rtl/flag_place.sv
module flag_place
    import simd_lane_compare_pkg::*;
#(
    parameter int NSLICE = DEF_WIDTH / DEF_SLICE
) (
    input  rel_t [NSLICE-1:0] acc_i,
    input  logic [NSLICE-2:0] cut_i,
    output logic [NSLICE-1:0] eq_o,
    output logic [NSLICE-1:0] ne_o,
    output logic [NSLICE-1:0] lt_o,
    output logic [NSLICE-1:0] le_o,
    output logic [NSLICE-1:0] gt_o,
    output logic [NSLICE-1:0] ge_o
);
    typedef struct packed {
        logic [NSLICE-1:0] eq;
        logic [NSLICE-1:0] ne;
        logic [NSLICE-1:0] lt;
        logic [NSLICE-1:0] le;
        logic [NSLICE-1:0] gt;
        logic [NSLICE-1:0] ge;
    } flags_t;

    logic [NSLICE-1:0] base;
    flags_t            flags_d;

    assign base = {cut_i, 1'b1};

    always_comb begin
        for (int k = 0; k < NSLICE; k++) begin
            flags_d.eq[k] = base[k] &  acc_i[k].eq;
            flags_d.ne[k] = base[k] & ~acc_i[k].eq;
            flags_d.gt[k] = base[k] &  acc_i[k].gt;
            flags_d.le[k] = base[k] & ~acc_i[k].gt;
            flags_d.ge[k] = base[k] & (acc_i[k].gt | acc_i[k].eq);
            flags_d.lt[k] = base[k] & ~(acc_i[k].gt | acc_i[k].eq);
        end
    end

    assign eq_o = flags_d.eq;
    assign ne_o = flags_d.ne;
    assign lt_o = flags_d.lt;
    assign le_o = flags_d.le;
    assign gt_o = flags_d.gt;
    assign ge_o = flags_d.ge;
endmodule

// File: rtl/simd_lane_compare.sv
module simd_lane_compare
    import simd_lane_compare_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int SLICE = DEF_SLICE,
    localparam int NSLICE = WIDTH / SLICE
) (
    input  logic [WIDTH-1:0]  opa_i,
    input  logic [WIDTH-1:0]  opb_i,
    input  logic [NSLICE-2:0] cut_i,
    output logic [NSLICE-1:0] eq_o,
    output logic [NSLICE-1:0] ne_o,
    output logic [NSLICE-1:0] lt_o,
    output logic [NSLICE-1:0] le_o,
    output logic [NSLICE-1:0] gt_o,
    output logic [NSLICE-1:0] ge_o
);
    rel_t [NSLICE-1:0] slice_rel_d;
    rel_t [NSLICE-1:0] acc_rel_d;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        slice_rel #(.SLICE(SLICE)) u_slice (
            .a_i  (opa_i[s*SLICE +: SLICE]),
            .b_i  (opb_i[s*SLICE +: SLICE]),
            .rel_o(slice_rel_d[s])
        );
    end

    lane_chain #(.NSLICE(NSLICE)) u_chain (
        .slice_i(slice_rel_d),
        .cut_i  (cut_i),
        .acc_o  (acc_rel_d)
    );

    flag_place #(.NSLICE(NSLICE)) u_place (
        .acc_i(acc_rel_d),
        .cut_i(cut_i),
        .eq_o (eq_o),
        .ne_o (ne_o),
        .lt_o (lt_o),
        .le_o (le_o),
        .gt_o (gt_o),
        .ge_o (ge_o)
    );
endmodule

// File: rtl/simd_lane_compare_chk.sv
module simd_lane_compare_chk #(
    parameter int WIDTH = 16,
    parameter int SLICE = 4,
    localparam int NSLICE = WIDTH / SLICE
) (
    input logic [WIDTH-1:0]  opa_i,
    input logic [WIDTH-1:0]  opb_i,
    input logic [NSLICE-2:0] cut_i,
    input logic [NSLICE-1:0] eq_o,
    input logic [NSLICE-1:0] ne_o,
    input logic [NSLICE-1:0] lt_o,
    input logic [NSLICE-1:0] le_o,
    input logic [NSLICE-1:0] gt_o,
    input logic [NSLICE-1:0] ge_o
);
    logic [NSLICE-1:0] base;
    assign base = {cut_i, 1'b1};

    always_comb begin
        AST_BASE_ONLY: assert (((eq_o | ne_o | lt_o | le_o | gt_o | ge_o) & ~base) == '0)
            else $error("flag outside lane base"); // R4
        AST_EQ_NE_SPLIT: assert ((eq_o ^ ne_o) == base)
            else $error("eq/ne not complementary"); // R2
        AST_ORDER_ONE: assert (((lt_o & eq_o) | (lt_o & gt_o) | (eq_o & gt_o)) == '0 && (lt_o | eq_o | gt_o) == base)
            else $error("order flags not exclusive"); // R5
        AST_LE_GE_FORM: assert (le_o == (lt_o | eq_o) && ge_o == (gt_o | eq_o))
            else $error("le/ge inconsistent"); // R5
        if (cut_i == '0) begin
            AST_WHOLE_LANE: assert (eq_o[0] == (opa_i == opb_i) && gt_o[0] == (opa_i > opb_i))
                else $error("whole lane mismatch"); // R3
        end
        if (&cut_i) begin
            for (int k = 0; k < NSLICE; k++) begin
                AST_SLICE_LANE: assert (eq_o[k] == (opa_i[k*SLICE +: SLICE] == opb_i[k*SLICE +: SLICE]) &&
                                        gt_o[k] == (opa_i[k*SLICE +: SLICE] >  opb_i[k*SLICE +: SLICE]))
                    else $error("slice lane mismatch"); // R6
            end
        end
    end
endmodule

bind simd_lane_compare simd_lane_compare_chk #(.WIDTH(WIDTH), .SLICE(SLICE)) u_chk (
    .opa_i(opa_i),
    .opb_i(opb_i),
    .cut_i(cut_i),
    .eq_o (eq_o),
    .ne_o (ne_o),
    .lt_o (lt_o),
    .le_o (le_o),
    .gt_o (gt_o),
    .ge_o (ge_o)
);

// File: tb/sim_simd_lane_compare.sv
`timescale 1ns/1ps
module sim_simd_lane_compare;
    localparam int W  = 16;
    localparam int SL = 4;
    localparam int NS = W / SL;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0]  a, b;
    logic [NS-2:0] cut;
    logic [NS-1:0] eq, ne, lt, le, gt, ge;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rng = 32'h1234_5678;

    simd_lane_compare #(.WIDTH(W), .SLICE(SL)) u0 (
        .opa_i(a), .opb_i(b), .cut_i(cut),
        .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Lane model: split the operands at the set cut bits, compare each field unsigned
    task automatic model(input logic [W-1:0] ma, input logic [W-1:0] mb, input logic [NS-2:0] mc,
                         output logic [NS-1:0] xeq, output logic [NS-1:0] xne,
                         output logic [NS-1:0] xlt, output logic [NS-1:0] xle,
                         output logic [NS-1:0] xgt, output logic [NS-1:0] xge);
        int s, e;
        longint unsigned va, vb, msk;
        xeq = '0; xne = '0; xlt = '0; xle = '0; xgt = '0; xge = '0;
        s = 0;
        while (s < NS) begin
            e = s;
            while (e < NS - 1 && !mc[e]) e++;
            msk = (64'd1 << (SL * (e - s + 1))) - 64'd1;
            va = (longint'(ma) >> (SL * s)) & msk;
            vb = (longint'(mb) >> (SL * s)) & msk;
            xeq[s] = (va == vb);
            xne[s] = (va != vb);
            xlt[s] = (va <  vb);
            xle[s] = (va <= vb);
            xgt[s] = (va >  vb);
            xge[s] = (va >= vb);
            s = e + 1;
        end
    endtask

    task automatic check(input string tag, input string what, input logic [NS-1:0] got, input logic [NS-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s a=%h b=%h cut=%b actual=%b expected=%b", tag, what, a, b, cut, got, exp);
        end
    endtask

    task automatic apply_and_check(input string tag, input logic [W-1:0] na, input logic [W-1:0] nb, input logic [NS-2:0] nc);
        logic [NS-1:0] xeq, xne, xlt, xle, xgt, xge;
        @(negedge clk);
        a = na; b = nb; cut = nc;
        #1;  // R10: results valid in the same cycle, no clock edge in between
        model(na, nb, nc, xeq, xne, xlt, xle, xgt, xge);
        check(tag, "eq R2", eq, xeq);
        check(tag, "ne R2", ne, xne);
        check(tag, "lt R5", lt, xlt);
        check(tag, "le R5", le, xle);
        check(tag, "gt R5", gt, xgt);
        check(tag, "ge R5", ge, xge);
    endtask

    function automatic string layout_tag(input logic [NS-2:0] c);
        if (c == '0) return "R3";
        if (c == 3'b010) return "R7";
        if (&c) return "R6";
        return "R9";
    endfunction

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        a = '0; b = '0; cut = '0;
        // Idle state: equal zero operands, one lane
        #1;
        check("R3", "idle eq", eq, 4'b0001);
        check("R4", "idle gt", gt, 4'b0000);

        // R7: two byte lanes, results at bits 0 and 2 only
        apply_and_check("R7", 16'h5A10, 16'h5A20, 3'b010);
        check("R7", "lt placement", lt, 4'b0001);
        check("R7", "eq placement", eq, 4'b0100);
        // R8: top bit set is greater when unsigned
        apply_and_check("R8", 16'h8888, 16'h7777, 3'b111);
        check("R8", "gt unsigned", gt, 4'b1111);
        apply_and_check("R8", 16'h8000, 16'h7FFF, 3'b000);
        check("R8", "gt whole unsigned", gt, 4'b0001);
        // R1: cut bit 0 separates slice 0 from slice 1
        apply_and_check("R1", 16'h0010, 16'h0001, 3'b001);
        check("R1", "lane split gt", gt, 4'b0010);
        check("R1", "lane split lt", lt, 4'b0001);
        // R9: a greater upper lane must not leak into a tied lower lane
        apply_and_check("R9", 16'hF000, 16'h0000, 3'b100);
        check("R9", "no leak eq", eq, 4'b0001);

        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    apply_and_check(layout_tag(3'(c)), {4{4'(x)}}, {4{4'(y)}}, 3'(c));
                end
            end
            for (int i = 0; i < 1024; i++) begin
                logic [W-1:0] ra, rb;
                rng = next_rng(rng); ra = rng[W-1:0];
                rng = next_rng(rng); rb = rng[W-1:0];
                rng = next_rng(rng);
                for (int k = 0; k < NS; k++)
                    if (rng[k] | rng[k+8]) rb[k*SL +: SL] = ra[k*SL +: SL];
                apply_and_check(layout_tag(3'(c)), ra, rb, 3'(c));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule